// File: doc/BRIEF.md
# Flash Program/Erase Pulse Timer

This block sets how long a flash program, page-erase, bulk-erase or verify step lasts in a small microcontroller. Software writes an 8-bit duration setting over a simple register bus, then raises one of four start inputs. The block clears a 10-bit interval counter, raises a high-voltage enable for the write and erase operations, and advances the counter on each single-cycle slow tick enable (nominally 128 kHz, in the system clock domain). When the counter has seen the number of ticks the operation calls for, the high-voltage enable drops and the done flag rises.

The done flag is active high: it reads 1 when the block is idle or an operation has finished, and 0 while an operation runs. A bulk erase takes twice as many ticks as a page operation for the same setting. Typical settings are 0xAF for page program or page erase and 0x57 for bulk erase. With 0xFF and a 7.8125 µs tick, a page operation lasts 512 ticks, about 4 ms.

Top module: `flash_pe_timer`

## Requirements
- R1: After reset the duration setting reads 0x00, doneFlag is 1 and hvEn is 0.
- R2: A bus write (busSel=1, busWr=1) with busAddr=0 stores busWdata as the duration setting; busRdata shows that setting when busAddr=0, and shows {7'b0, doneFlag} when busAddr=1.
- R3: A program or page-erase start makes the operation last exactly 2*(S+1) ticks, where S is the setting, with hvEn held at 1 for the whole operation.
- R4: A bulk-erase start makes the operation last exactly 4*(S+1) ticks, with hvEn held at 1; S=0xFF gives 1024 ticks.
- R5: A verify start makes the operation last exactly 2 ticks whatever the setting, and hvEn stays 0.
- R6: On the clock edge that samples a start while idle, doneFlag falls and hvEn rises (for non-verify); on the edge that samples the last tick, doneFlag rises and hvEn falls together. A tick in the same cycle as the start is not counted.
- R7: A start input raised while an operation runs is ignored: the running operation keeps its type and length.
- R8: Writing the setting while an operation runs does not change that operation's length; the new value applies from the next start.
- R9: When several starts are raised together, bulk erase wins over page erase, page erase over program, and program over verify.
- R10: Ticks that arrive while idle have no effect on the length of a later operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register bus select |
| busWr | input | 1 | Register bus write strobe |
| busAddr | input | 1 | 0 = duration setting, 1 = status |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| tick | input | 1 | Single-cycle slow tick enable |
| startProg | input | 1 | Start byte/page program |
| startPage | input | 1 | Start page erase |
| startBulk | input | 1 | Start bulk erase |
| startVerify | input | 1 | Start verify |
| hvEn | output | 1 | High-voltage enable |
| doneFlag | output | 1 | 1 = idle or finished, 0 = busy |

## Verification
A start held for one cycle shows its effect on doneFlag and hvEn one clock edge later, so the bench drives inputs on the falling edge and samples both outputs on the next falling edge. Each tick is also held for one cycle, and the bench samples doneFlag after the edge that took it, counting ticks until the flag rises and comparing that count with 2*(S+1), 4*(S+1) or 2. Register reads are combinational and are sampled in the same cycle the address is set.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_PAGE   = 2'd1,
    OP_BULK   = 2'd2,
    OP_VERIFY = 2'd3
  } opKind_e;

  typedef struct packed {
    logic    clrCnt;
    logic    incCnt;
    logic    loadTerm;
    opKind_e kind;
  } dpCtrl_t;
endpackage

// File: rtl/fpt_datapath.sv
module fpt_datapath
  import fpt_pkg::*;
#(
  parameter int CTRL_W       = 8,
  parameter int VERIFY_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  input  dpCtrl_t           ctrl,
  output logic [CTRL_W-1:0] setting,
  output logic              atTerm
);
  localparam int CNT_W = CTRL_W + 2;
  localparam logic [CNT_W-1:0] VER_TERM = CNT_W'(VERIFY_TICKS - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] termReg;
  logic [CNT_W-1:0] termNext;

  // Duration setting register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) setting <= '0;
    else if (regWrEn) setting <= regWrData;
  end

  // Terminal count chosen by operation kind
  always_comb begin
    unique case (ctrl.kind)
      OP_BULK:   termNext = {setting, 2'b11};
      OP_VERIFY: termNext = VER_TERM;
      default:   termNext = {1'b0, setting, 1'b1};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) termReg <= '0;
    else if (ctrl.loadTerm) termReg <= termNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (ctrl.clrCnt) cnt <= '0;
    else if (ctrl.incCnt) cnt <= cnt + 1'b1;
  end

  assign atTerm = (cnt == termReg);
endmodule

// File: rtl/fpt_control.sv
module fpt_control
  import fpt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    startProg,
  input  logic    startPage,
  input  logic    startBulk,
  input  logic    startVerify,
  input  logic    atTerm,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    hvEn
);
  logic    anyStart;
  logic    startOk;
  logic    finish;
  opKind_e kindSel;

  always_comb begin
    anyStart = startProg | startPage | startBulk | startVerify;
    if (startBulk)      kindSel = OP_BULK;
    else if (startPage) kindSel = OP_PAGE;
    else if (startProg) kindSel = OP_PROG;
    else                kindSel = OP_VERIFY;
    startOk = !busy && anyStart;
    finish  = busy && tick && atTerm;
    ctrl.clrCnt   = startOk;
    ctrl.loadTerm = startOk;
    ctrl.incCnt   = busy && tick && !atTerm;
    ctrl.kind     = kindSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      hvEn <= 1'b0;
    end else if (startOk) begin
      busy <= 1'b1;
      hvEn <= (kindSel != OP_VERIFY);
    end else if (finish) begin
      busy <= 1'b0;
      hvEn <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_pe_timer.sv
module flash_pe_timer
  import fpt_pkg::*;
#(
  parameter int CTRL_W       = 8,
  parameter int VERIFY_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [CTRL_W-1:0] busWdata,
  output logic [CTRL_W-1:0] busRdata,
  input  logic              tick,
  input  logic              startProg,
  input  logic              startPage,
  input  logic              startBulk,
  input  logic              startVerify,
  output logic              hvEn,
  output logic              doneFlag
);
  dpCtrl_t           ctrl;
  logic              atTerm;
  logic              busy;
  logic [CTRL_W-1:0] setting;

  fpt_control u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .startProg(startProg), .startPage(startPage),
    .startBulk(startBulk), .startVerify(startVerify),
    .atTerm(atTerm), .ctrl(ctrl), .busy(busy), .hvEn(hvEn)
  );

  fpt_datapath #(.CTRL_W(CTRL_W), .VERIFY_TICKS(VERIFY_TICKS)) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(busSel && busWr && !busAddr),
    .regWrData(busWdata), .ctrl(ctrl),
    .setting(setting), .atTerm(atTerm)
  );

  assign doneFlag = !busy;
  assign busRdata = busAddr ? {{(CTRL_W-1){1'b0}}, doneFlag} : setting;
endmodule

// File: rtl/flash_pe_timer_chk.sv
module flash_pe_timer_chk (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic startProg,
  input logic startPage,
  input logic startBulk,
  input logic startVerify,
  input logic hvEn,
  input logic doneFlag
);
  logic hvStart;
  assign hvStart = startProg | startPage | startBulk;

  AST_HV_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    hvEn |-> !doneFlag); // R6
  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && (hvStart || startVerify)) |=> !doneFlag); // R6
  AST_HV_ON_WRITE_START: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && hvStart) |=> hvEn); // R3
  AST_VERIFY_NO_HV: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && startVerify && !hvStart) |=> !hvEn); // R5
  AST_END_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!doneFlag && !tick) |=> !doneFlag); // R3
  AST_HV_DROPS_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !hvEn); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (!doneFlag && !hvEn) |=> !hvEn); // R7
endmodule

bind flash_pe_timer flash_pe_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .tick(tick),
  .startProg(startProg), .startPage(startPage),
  .startBulk(startBulk), .startVerify(startVerify),
  .hvEn(hvEn), .doneFlag(doneFlag)
);

// File: tb/flash_pe_timer_tb.sv
module flash_pe_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       tick = 1'b0;
  logic       startProg = 1'b0, startPage = 1'b0, startBulk = 1'b0, startVerify = 1'b0;
  logic       hvEn, doneFlag;
  int         nChecks = 0;
  int         nFails  = 0;

  always #10 clk = ~clk;

  flash_pe_timer u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tick(tick),
    .startProg(startProg), .startPage(startPage), .startBulk(startBulk),
    .startVerify(startVerify), .hvEn(hvEn), .doneFlag(doneFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] v);
    busSel = 1'b1; busWr = 1'b1; busAddr = 1'b0; busWdata = v;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic regRead(input logic a, output logic [7:0] v);
    busAddr = a;
    #1 v = busRdata;
  endtask

  // starts: {bulk,page,prog,verify}; tickWithStart adds a same-cycle tick
  task automatic startOp(input logic [3:0] s, input bit tickWithStart, input bit expHv, input string req);
    {startBulk, startPage, startProg, startVerify} = s;
    tick = tickWithStart;
    @(negedge clk);
    {startBulk, startPage, startProg, startVerify} = 4'b0;
    tick = 1'b0;
    check({req, " R6 busy after start"}, doneFlag, 0);
    check({req, " hvEn after start"}, hvEn, expHv);
  endtask

  // injKind: 0 none, 1 raise startBulk at tick injAt, 2 write register at tick injAt
  task automatic runTicks(input int gap, input bit expHv, input int injKind, input int injAt,
                          output int n, output int hvBad);
    n = 0; hvBad = 0;
    while (n < 3000) begin
      tick = 1'b1;
      if (injKind == 1 && n == injAt) startBulk = 1'b1;
      if (injKind == 2 && n == injAt) begin
        busSel = 1'b1; busWr = 1'b1; busAddr = 1'b0; busWdata = 8'h40;
      end
      @(negedge clk);
      tick = 1'b0; startBulk = 1'b0; busSel = 1'b0; busWr = 1'b0;
      n++;
      if (doneFlag) begin
        if (hvEn) hvBad++;
        break;
      end
      if (hvEn != expHv) hvBad++;
      repeat (gap) begin
        @(negedge clk);
        if (doneFlag || hvEn != expHv) hvBad++;
      end
    end
  endtask

  task automatic fullOp(input logic [7:0] setv, input logic [3:0] s, input int gap,
                        input bit expHv, input int expTicks, input string req);
    int n, hvBad;
    regWrite(setv);
    startOp(s, 1'b0, expHv, req);
    runTicks(gap, expHv, 0, 0, n, hvBad);
    check({req, " tick count"}, n, expTicks);
    check({req, " hvEn during op / R6 end"}, hvBad, 0);
  endtask

  initial begin
    logic [7:0] rv;
    int n, hvBad;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    regRead(1'b0, rv); check("R1 setting reset", rv, 0);
    check("R1 doneFlag reset", doneFlag, 1);
    check("R1 hvEn reset", hvEn, 0);
    // R2
    for (int v = 0; v < 256; v += 37) begin
      regWrite(8'(v)); regRead(1'b0, rv); check("R2 setting readback", rv, v);
    end
    busSel = 1'b0; busWr = 1'b1; busWdata = 8'h11; @(negedge clk); busWr = 1'b0;
    regRead(1'b0, rv); check("R2 write without select ignored", rv, 222);
    busSel = 1'b1; busWr = 1'b1; busAddr = 1'b1; busWdata = 8'h33; @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    regRead(1'b0, rv); check("R2 write to status ignored", rv, 222);
    regRead(1'b1, rv); check("R2 status idle", rv, 1);
    // R3 sweep program and page erase
    for (int t = 0; t < 24; t++) begin
      fullOp(8'(t), 4'b0010, 0, 1'b1, 2*(t+1), "R3 program");
      fullOp(8'(t), 4'b0100, t % 3, 1'b1, 2*(t+1), "R3 page");
    end
    fullOp(8'hAF, 4'b0100, 0, 1'b1, 352, "R3 page 0xAF");
    fullOp(8'hFF, 4'b0010, 0, 1'b1, 512, "R3 program 0xFF");
    // R4 bulk
    for (int t = 0; t < 16; t++) fullOp(8'(t), 4'b1000, t % 2, 1'b1, 4*(t+1), "R4 bulk");
    fullOp(8'h57, 4'b1000, 0, 1'b1, 352, "R4 bulk 0x57");
    fullOp(8'hFF, 4'b1000, 0, 1'b1, 1024, "R4 bulk 0xFF");
    // R5 verify
    fullOp(8'h00, 4'b0001, 0, 1'b0, 2, "R5 verify s=0");
    fullOp(8'hFF, 4'b0001, 2, 1'b0, 2, "R5 verify s=FF");
    // R2 status while busy
    regWrite(8'd3); startOp(4'b0100, 1'b0, 1'b1, "R2");
    regRead(1'b1, rv); check("R2 status busy", rv, 0);
    runTicks(0, 1'b1, 0, 0, n, hvBad); check("R2 op length", n, 8);
    // R6 tick with start not counted
    regWrite(8'd2); startOp(4'b0010, 1'b1, 1'b1, "R6");
    runTicks(0, 1'b1, 0, 0, n, hvBad); check("R6 same-cycle tick ignored", n, 6);
    // R7 start while busy
    regWrite(8'd5); startOp(4'b0010, 1'b0, 1'b1, "R7");
    runTicks(0, 1'b1, 1, 3, n, hvBad); check("R7 mid-op bulk ignored", n, 12);
    check("R7 hvEn", hvBad, 0);
    startOp(4'b0001, 1'b0, 1'b0, "R7 verify");
    {startBulk, startPage, startProg} = 3'b111; @(negedge clk);
    {startBulk, startPage, startProg} = 3'b000;
    check("R7 verify ignores write start hvEn", hvEn, 0);
    runTicks(0, 1'b0, 0, 0, n, hvBad); check("R7 verify length kept", n, 2);
    // R8 register write mid-op
    regWrite(8'd4); startOp(4'b0100, 1'b0, 1'b1, "R8");
    runTicks(1, 1'b1, 2, 2, n, hvBad); check("R8 running op keeps length", n, 10);
    regRead(1'b0, rv); check("R8 new value stored", rv, 8'h40);
    startOp(4'b0100, 1'b0, 1'b1, "R8");
    runTicks(0, 1'b1, 0, 0, n, hvBad); check("R8 next op uses new value", n, 130);
    // R9 priority
    fullOp(8'd3, 4'b1111, 0, 1'b1, 16, "R9 all -> bulk");
    fullOp(8'd3, 4'b0111, 0, 1'b1, 8, "R9 page+prog+verify -> page");
    fullOp(8'd3, 4'b0011, 0, 1'b1, 8, "R9 prog+verify -> prog");
    // R10 idle ticks
    regWrite(8'd6);
    tick = 1'b1; repeat (20) @(negedge clk); tick = 1'b0;
    check("R10 idle ticks keep done", doneFlag, 1);
    startOp(4'b0010, 1'b0, 1'b1, "R10");
    runTicks(0, 1'b1, 0, 0, n, hvBad); check("R10 full length after idle ticks", n, 14);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule